// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block caches page translations for a processor's memory pipeline. Each slot holds a virtual page number, an address-space tag, a physical frame number, a 2-bit protection code and three state bits: valid, referenced and modified. A lookup compares the requested page and address-space tag against every slot at once. The result comes back in the same cycle: a hit flag, the frame number, the protection code, and the slot's referenced and modified bits as they stood before the access.

Because every slot carries an address-space tag, translations from several processes can stay resident across a context switch. Software refills the cache through a fill port after a miss. The slot for a fill is picked in a fixed order: a slot that already holds the same key, then the lowest-numbered empty slot, then the slot used least recently. Two flush inputs clear the whole cache or only the slots of one address space. The slot count is a parameter that must lie between 16 and 48; elaboration stops with an error for any value outside that range.

Top module: `xlat_tlb`

## Requirements
- R1: After reset every slot is invalid, so every lookup misses and reports frame 0, protection 0, referenced 0 and modified 0.
- R2: A lookup with `lk_en` high hits only when a valid slot has the same 20-bit page number and the same 4-bit address-space tag. On a hit, `lk_pfn` and `lk_prot` carry that slot's stored fields in the same cycle.
- R3: A slot written by a fill reports referenced 0 and modified 0. A hit on a read sets referenced. A hit with `lk_write` high sets both referenced and modified. The new bits show from the next cycle on.
- R4: If no valid slot holds the fill key, the fill writes the lowest-numbered invalid slot when one exists, so no valid translation is evicted while a slot is free.
- R5: A fill whose page and tag match a valid slot overwrites that slot in place. The frame and protection are replaced, referenced and modified are cleared, and no second copy of the key is created.
- R6: When all slots are valid and the fill key is not present, the fill replaces the slot least recently used. A use is a fill or a lookup hit; a miss is not a use.
- R7: `flush_all` invalidates every slot at the next clock edge.
- R8: `flush_asid_en` invalidates, at the next clock edge, exactly the valid slots whose tag equals `flush_asid`. Slots of other address spaces stay valid.
- R9: A fill presented in the same cycle as either flush is dropped. A lookup hit presented in the same cycle as a fill or a flush does not change the referenced bits, the modified bits or the use order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst_n | input | 1 | Active-low reset |
| lk_en | input | 1 | Lookup request this cycle |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_asid | input | 4 | Address-space tag of the requester |
| lk_write | input | 1 | Lookup is for a store |
| lk_hit | output | 1 | A valid slot matched page and tag |
| lk_pfn | output | 20 | Frame number of the matching slot |
| lk_prot | output | 2 | Protection code of the matching slot |
| lk_ref | output | 1 | Referenced bit of the matching slot before this access |
| lk_mod | output | 1 | Modified bit of the matching slot before this access |
| fill_en | input | 1 | Write a translation this cycle |
| fill_vpn | input | 20 | Page number of the new translation |
| fill_asid | input | 4 | Address-space tag of the new translation |
| fill_pfn | input | 20 | Frame number of the new translation |
| fill_prot | input | 2 | Protection code of the new translation |
| flush_all | input | 1 | Invalidate every slot |
| flush_asid_en | input | 1 | Invalidate the slots of one address space |
| flush_asid | input | 4 | Address-space tag to flush |

## Verification
Lookups are run against the same page number under two address-space tags, and against neighbouring page numbers under one tag. This shows whether both key fields take part in the match. After the cache is filled, a chosen set of slots is touched by lookup hits while misses are mixed in. The next fill must then evict the one untouched slot, which separates true use order from fill order and from schemes where misses also count as use. A per-tag flush followed by exactly as many fills as it freed shows whether fills prefer empty slots, since any eviction would make a surviving translation miss. Cycles that combine a fill with a hit, or a flush with a fill, show which operation takes effect.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   localparam int VPN_W  = 20;
   localparam int ASID_W = 4;
   localparam int PFN_W  = 20;
   localparam int PROT_W = 2;

   typedef logic [VPN_W-1:0]  vpn_t;
   typedef logic [ASID_W-1:0] asid_t;
   typedef logic [PFN_W-1:0]  pfn_t;
   typedef logic [PROT_W-1:0] prot_t;

   typedef struct packed {
      logic  valid;
      logic  refd;
      logic  modf;
      prot_t prot;
      asid_t asid;
      vpn_t  vpn;
      pfn_t  pfn;
   } slot_t;

endpackage

// File: rtl/xlat_cam.sv
module xlat_cam #(
   parameter int N     = 16,
   parameter int IDX_W = $clog2(N)
) (
   input  xlat_pkg::slot_t [N-1:0] tbl,
   input  xlat_pkg::vpn_t          key_vpn,
   input  xlat_pkg::asid_t         key_asid,
   output logic [N-1:0]            match_vec,
   output logic                    match_any,
   output logic [IDX_W-1:0]        match_idx
);

   generate
      if (N < 2) begin : g_bad_n
         $error("xlat_cam needs at least two slots");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_cmp
         assign match_vec[gi] = tbl[gi].valid &&
                                (tbl[gi].vpn == key_vpn) &&
                                (tbl[gi].asid == key_asid);
      end
   endgenerate

   assign match_any = |match_vec;

   // Encoder assumes at most one slot matches (no duplicate keys).
   always_comb begin
      match_idx = '0;
      for (int i = 0; i < N; i++) begin
         if (match_vec[i]) match_idx = match_idx | IDX_W'(i);
      end
   end

endmodule

// File: rtl/xlat_free.sv
module xlat_free #(
   parameter int N     = 16,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     valid_vec,
   output logic             free_any,
   output logic [IDX_W-1:0] free_idx
);

   assign free_any = ~&valid_vec;

   // Scan downward so that the lowest invalid slot is the last assignment.
   always_comb begin
      free_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!valid_vec[i]) free_idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/xlat_lru.sv
module xlat_lru #(
   parameter int N     = 16,
   parameter int IDX_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch_en,
   input  logic [IDX_W-1:0] touch_idx,
   output logic [IDX_W-1:0] victim_idx
);

   localparam logic [IDX_W-1:0] OLDEST = IDX_W'(N - 1);

   generate
      if (N < 2) begin : g_bad_n
         $error("xlat_lru needs at least two slots");
      end
   endgenerate

   logic [IDX_W-1:0] age [N];
   logic [IDX_W-1:0] touched_age;
   logic [N-1:0]     oldest_vec;

   assign touched_age = age[touch_idx];

   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_age
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               age[gi] <= IDX_W'(gi);
            end else if (touch_en) begin
               if (touch_idx == IDX_W'(gi)) begin
                  age[gi] <= '0;
               end else if (age[gi] < touched_age) begin
                  age[gi] <= age[gi] + 1'b1;
               end
            end
         end

         assign oldest_vec[gi] = (age[gi] == OLDEST);

         p_touch_youngest_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (touch_en && touch_idx == IDX_W'(gi)) |=> (age[gi] == '0));
      end
   endgenerate

   always_comb begin
      victim_idx = '0;
      for (int i = 0; i < N; i++) begin
         if (oldest_vec[i]) victim_idx = IDX_W'(i);
      end
   end

   // Ages stay a permutation: exactly one slot is the oldest.
   p_single_oldest_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(oldest_vec) == 1);

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
   parameter int ENTRIES = 16,
   parameter int IDX_W   = $clog2(ENTRIES)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        lk_en,
   input  logic [xlat_pkg::VPN_W-1:0]  lk_vpn,
   input  logic [xlat_pkg::ASID_W-1:0] lk_asid,
   input  logic                        lk_write,
   output logic                        lk_hit,
   output logic [xlat_pkg::PFN_W-1:0]  lk_pfn,
   output logic [xlat_pkg::PROT_W-1:0] lk_prot,
   output logic                        lk_ref,
   output logic                        lk_mod,
   input  logic                        fill_en,
   input  logic [xlat_pkg::VPN_W-1:0]  fill_vpn,
   input  logic [xlat_pkg::ASID_W-1:0] fill_asid,
   input  logic [xlat_pkg::PFN_W-1:0]  fill_pfn,
   input  logic [xlat_pkg::PROT_W-1:0] fill_prot,
   input  logic                        flush_all,
   input  logic                        flush_asid_en,
   input  logic [xlat_pkg::ASID_W-1:0] flush_asid
);

   import xlat_pkg::*;

   generate
      if (ENTRIES < 16 || ENTRIES > 48) begin : g_bad_entries
         $error("xlat_tlb: ENTRIES must lie in 16..48");
      end
   endgenerate

   slot_t [ENTRIES-1:0] tbl;
   logic  [ENTRIES-1:0] valid_vec;
   logic  [ENTRIES-1:0] lk_vec;
   logic  [ENTRIES-1:0] fk_vec;
   logic                lk_any, fk_any, free_any;
   logic  [IDX_W-1:0]   lk_idx, fk_idx, free_idx, victim_idx;
   logic  [IDX_W-1:0]   fill_slot, touch_idx;
   logic                flush_any, do_fill, do_touch, touch_en;

   // Lookup key comparison
   xlat_cam #(.N(ENTRIES), .IDX_W(IDX_W)) lk_cam_i (
      .tbl(tbl), .key_vpn(lk_vpn), .key_asid(lk_asid),
      .match_vec(lk_vec), .match_any(lk_any), .match_idx(lk_idx));

   // Fill key comparison, for in-place overwrite
   xlat_cam #(.N(ENTRIES), .IDX_W(IDX_W)) fk_cam_i (
      .tbl(tbl), .key_vpn(fill_vpn), .key_asid(fill_asid),
      .match_vec(fk_vec), .match_any(fk_any), .match_idx(fk_idx));

   xlat_free #(.N(ENTRIES), .IDX_W(IDX_W)) free_i (
      .valid_vec(valid_vec), .free_any(free_any), .free_idx(free_idx));

   xlat_lru #(.N(ENTRIES), .IDX_W(IDX_W)) lru_i (
      .clk(clk), .rst_n(rst_n), .touch_en(touch_en),
      .touch_idx(touch_idx), .victim_idx(victim_idx));

   assign flush_any = flush_all | flush_asid_en;
   assign do_fill   = fill_en & ~flush_any;
   assign do_touch  = lk_hit & ~fill_en & ~flush_any;
   assign touch_en  = do_fill | do_touch;
   assign touch_idx = do_fill ? fill_slot : lk_idx;

   always_comb begin
      if (fk_any)        fill_slot = fk_idx;
      else if (free_any) fill_slot = free_idx;
      else               fill_slot = victim_idx;
   end

   assign lk_hit = lk_en & lk_any;

   // AND-OR read mux over the (at most one-hot) match vector
   always_comb begin
      lk_pfn  = '0;
      lk_prot = '0;
      lk_ref  = 1'b0;
      lk_mod  = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (lk_en && lk_vec[i]) begin
            lk_pfn  = lk_pfn  | tbl[i].pfn;
            lk_prot = lk_prot | tbl[i].prot;
            lk_ref  = lk_ref  | tbl[i].refd;
            lk_mod  = lk_mod  | tbl[i].modf;
         end
      end
   end

   genvar gi;
   generate
      for (gi = 0; gi < ENTRIES; gi++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tbl[gi] <= '0;
            end else if (flush_all) begin
               tbl[gi].valid <= 1'b0;
            end else if (flush_asid_en) begin
               if (tbl[gi].asid == flush_asid) tbl[gi].valid <= 1'b0;
            end else if (do_fill && fill_slot == IDX_W'(gi)) begin
               tbl[gi].valid <= 1'b1;
               tbl[gi].refd  <= 1'b0;
               tbl[gi].modf  <= 1'b0;
               tbl[gi].prot  <= fill_prot;
               tbl[gi].asid  <= fill_asid;
               tbl[gi].vpn   <= fill_vpn;
               tbl[gi].pfn   <= fill_pfn;
            end else if (do_touch && lk_idx == IDX_W'(gi)) begin
               tbl[gi].refd <= 1'b1;
               if (lk_write) tbl[gi].modf <= 1'b1;
            end
         end

         assign valid_vec[gi] = tbl[gi].valid;

         p_flush_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
            flush_all |=> !tbl[gi].valid);

         p_asid_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (flush_asid_en && tbl[gi].asid == flush_asid) |=> !tbl[gi].valid);

         p_asid_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!flush_all && flush_asid_en && tbl[gi].valid &&
             tbl[gi].asid != flush_asid) |=> tbl[gi].valid);

         p_quiet_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (flush_any || (fill_en && fill_slot != IDX_W'(gi)))
            |=> (tbl[gi].modf == $past(tbl[gi].modf) &&
                 tbl[gi].refd == $past(tbl[gi].refd)));

         p_fill_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (do_fill && fill_slot == IDX_W'(gi))
            |=> (tbl[gi].valid && tbl[gi].vpn == $past(fill_vpn) &&
                 tbl[gi].asid == $past(fill_asid) && !tbl[gi].modf));
      end
   endgenerate

   // No key is ever held twice, so a lookup matches at most one slot.
   p_unique_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_vec));

   p_flush_blocks_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_all && fill_en) |=> (valid_vec == '0));

endmodule

// File: tb/xlat_tlb_tb_top.sv
module xlat_tlb_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int ENT        = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_en = 1'b0, lk_write = 1'b0;
   logic [19:0] lk_vpn = '0;
   logic [3:0]  lk_asid = '0;
   logic        lk_hit, lk_ref, lk_mod;
   logic [19:0] lk_pfn;
   logic [1:0]  lk_prot;
   logic        fill_en = 1'b0;
   logic [19:0] fill_vpn = '0, fill_pfn = '0;
   logic [3:0]  fill_asid = '0;
   logic [1:0]  fill_prot = '0;
   logic        flush_all = 1'b0, flush_asid_en = 1'b0;
   logic [3:0]  flush_asid = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xlat_tlb #(.ENTRIES(ENT)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .lk_en(lk_en), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_write(lk_write),
      .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_prot(lk_prot),
      .lk_ref(lk_ref), .lk_mod(lk_mod),
      .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
      .fill_pfn(fill_pfn), .fill_prot(fill_prot),
      .flush_all(flush_all), .flush_asid_en(flush_asid_en), .flush_asid(flush_asid));

   typedef struct {
      logic        hit;
      logic [19:0] pfn;
      logic [1:0]  prot;
      logic        rf;
      logic        md;
      string       req;
   } exp_t;

   exp_t exp_q[$];
   int   n_cmp = 0, n_bad = 0;
   bit   done = 0;

   // Reference model: per-slot fields plus a last-use stamp
   logic        m_v [ENT];
   logic [19:0] m_vpn [ENT], m_pfn [ENT];
   logic [3:0]  m_asid [ENT];
   logic [1:0]  m_prot [ENT];
   logic        m_rf [ENT], m_md [ENT];
   int          m_ts [ENT];
   int          now = 0;

   function automatic int m_find(logic [19:0] v, logic [3:0] a);
      for (int i = 0; i < ENT; i++)
         if (m_v[i] && m_vpn[i] == v && m_asid[i] == a) return i;
      return -1;
   endfunction

   function automatic int m_pick(logic [19:0] v, logic [3:0] a);
      int best;
      best = m_find(v, a);
      if (best >= 0) return best;
      for (int i = 0; i < ENT; i++) if (!m_v[i]) return i;
      best = 0;
      for (int i = 1; i < ENT; i++) if (m_ts[i] < m_ts[best]) best = i;
      return best;
   endfunction

   task automatic step(input bit le, input logic [19:0] lv, input logic [3:0] la,
                       input bit lw, input bit fe, input logic [19:0] fv,
                       input logic [3:0] fa, input logic [19:0] fp,
                       input logic [1:0] fr, input bit fl_all, input bit fl_as,
                       input logic [3:0] fl_a, input string req);
      exp_t e;
      int   h;
      @(posedge clk);
      #1;
      lk_en = le; lk_vpn = lv; lk_asid = la; lk_write = lw;
      fill_en = fe; fill_vpn = fv; fill_asid = fa; fill_pfn = fp; fill_prot = fr;
      flush_all = fl_all; flush_asid_en = fl_as; flush_asid = fl_a;
      h = le ? m_find(lv, la) : -1;
      if (le) begin
         e.hit = (h >= 0);
         e.pfn = (h >= 0) ? m_pfn[h] : '0;
         e.prot = (h >= 0) ? m_prot[h] : '0;
         e.rf = (h >= 0) ? m_rf[h] : 1'b0;
         e.md = (h >= 0) ? m_md[h] : 1'b0;
         e.req = req;
         exp_q.push_back(e);
      end
      if (fl_all) begin
         for (int i = 0; i < ENT; i++) m_v[i] = 1'b0;
      end else if (fl_as) begin
         for (int i = 0; i < ENT; i++) if (m_asid[i] == fl_a) m_v[i] = 1'b0;
      end else if (fe) begin
         int s;
         s = m_pick(fv, fa);
         m_v[s] = 1'b1; m_vpn[s] = fv; m_asid[s] = fa; m_pfn[s] = fp;
         m_prot[s] = fr; m_rf[s] = 1'b0; m_md[s] = 1'b0;
         now++; m_ts[s] = now;
      end else if (h >= 0) begin
         m_rf[h] = 1'b1;
         if (lw) m_md[h] = 1'b1;
         now++; m_ts[h] = now;
      end
   endtask

   task automatic look(input logic [19:0] v, input logic [3:0] a, input bit w,
                       input string req);
      step(1, v, a, w, 0, '0, '0, '0, '0, 0, 0, '0, req);
   endtask

   task automatic fill(input logic [19:0] v, input logic [3:0] a,
                       input logic [19:0] p, input logic [1:0] r, input string req);
      step(0, '0, '0, 0, 1, v, a, p, r, 0, 0, '0, req);
   endtask

   task automatic idle();
      step(0, '0, '0, 0, 0, '0, '0, '0, '0, 0, 0, '0, "idle");
   endtask

   // Monitor: compare the combinational lookup result mid-cycle
   always @(negedge clk) begin
      if (rst_n && lk_en && !done) begin
         exp_t e;
         n_cmp++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL scoreboard: result with no expected item (actual hit=%0b, expected none)", lk_hit);
         end else begin
            e = exp_q.pop_front();
            if (lk_hit !== e.hit || lk_pfn !== e.pfn || lk_prot !== e.prot ||
                lk_ref !== e.rf || lk_mod !== e.md) begin
               n_bad++;
               $display("FAIL %s: actual hit=%0b pfn=%h prot=%0d ref=%0b mod=%0b expected hit=%0b pfn=%h prot=%0d ref=%0b mod=%0b",
                        e.req, lk_hit, lk_pfn, lk_prot, lk_ref, lk_mod,
                        e.hit, e.pfn, e.prot, e.rf, e.md);
            end
         end
      end
   end

   function automatic logic [19:0] pf(int k);
      return 20'hA0000 ^ 20'(k * 37 + 5);
   endfunction

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         done = 1;
         n_bad++;
         $display("FAIL watchdog: actual run still going, expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < ENT; i++) begin
         m_v[i] = 0; m_vpn[i] = '0; m_asid[i] = '0; m_pfn[i] = '0;
         m_prot[i] = '0; m_rf[i] = 0; m_md[i] = 0; m_ts[i] = 0;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: empty after reset
      look(20'h00100, 4'd1, 0, "R1");
      look(20'h00000, 4'd0, 0, "R1");
      look(20'hFFFFF, 4'd15, 0, "R1");

      // R2: both key fields must match
      fill(20'h00100, 4'd1, 20'h12345, 2'd2, "R2");
      look(20'h00100, 4'd1, 0, "R2");
      look(20'h00100, 4'd2, 0, "R2");
      look(20'h00101, 4'd1, 0, "R2");
      look(20'h00000, 4'd1, 0, "R2");

      // R3: referenced/modified bookkeeping
      look(20'h00100, 4'd1, 0, "R3");
      look(20'h00100, 4'd1, 1, "R3");
      look(20'h00100, 4'd1, 0, "R3");

      // R5: same key overwritten in place, bits cleared
      fill(20'h00100, 4'd1, 20'h0BEEF, 2'd1, "R5");
      look(20'h00100, 4'd1, 0, "R5");

      // Fill the remaining slots across two address spaces
      for (int k = 1; k < ENT; k++)
         fill(20'h00100 + 20'(k), (k % 2 == 0) ? 4'd1 : 4'd2, pf(k), 2'(k), "R4");
      for (int k = 0; k < ENT; k++)
         look(20'h00100 + 20'(k), (k == 0 || k % 2 == 0) ? 4'd1 : 4'd2, 0, "R5");

      // R6: touch all but one slot, then mix in misses, then evict
      for (int k = 0; k < ENT; k++)
         if (k != 6) look(20'h00100 + 20'(k), (k == 0 || k % 2 == 0) ? 4'd1 : 4'd2, 0, "R6");
      look(20'h00106, 4'd9, 0, "R6");
      look(20'h77777, 4'd1, 0, "R6");
      fill(20'h00200, 4'd3, 20'h00AAA, 2'd3, "R6");
      look(20'h00106, 4'd1, 0, "R6");
      look(20'h00200, 4'd3, 0, "R6");
      for (int k = 0; k < ENT; k++)
         if (k != 6) look(20'h00100 + 20'(k), (k == 0 || k % 2 == 0) ? 4'd1 : 4'd2, 0, "R6");
      fill(20'h00201, 4'd3, 20'h00BBB, 2'd0, "R6");
      look(20'h00200, 4'd3, 0, "R6");
      look(20'h00201, 4'd3, 0, "R6");

      // R8: drop only address space 2
      step(0, '0, '0, 0, 0, '0, '0, '0, '0, 0, 1, 4'd2, "R8");
      for (int k = 0; k < ENT; k++)
         look(20'h00100 + 20'(k), (k == 0 || k % 2 == 0) ? 4'd1 : 4'd2, 0, "R8");
      look(20'h00201, 4'd3, 0, "R8");

      // R4: refill freed slots; nothing valid may be evicted
      for (int k = 0; k < 8; k++)
         fill(20'h00300 + 20'(k), 4'd4, pf(k + 40), 2'd1, "R4");
      for (int k = 0; k < 8; k++)
         look(20'h00300 + 20'(k), 4'd4, 0, "R4");
      for (int k = 0; k < ENT; k += 2)
         if (k != 6) look(20'h00100 + 20'(k), 4'd1, 0, "R4");
      look(20'h00201, 4'd3, 0, "R4");

      // R9: a write hit during a fill leaves the bits alone
      look(20'h00300, 4'd4, 0, "R9");
      step(1, 20'h00300, 4'd4, 1, 1, 20'h00400, 4'd5, 20'h00CCC, 2'd2, 0, 0, '0, "R9");
      look(20'h00300, 4'd4, 0, "R9");
      look(20'h00400, 4'd5, 0, "R9");
      // R9: flush wins over a fill in the same cycle
      step(0, '0, '0, 0, 1, 20'h00500, 4'd6, 20'h00DDD, 2'd1, 0, 1, 4'd7, "R9");
      look(20'h00500, 4'd6, 0, "R9");

      // R7: flush everything
      step(0, '0, '0, 0, 0, '0, '0, '0, '0, 1, 0, '0, "R7");
      look(20'h00300, 4'd4, 0, "R7");
      look(20'h00100, 4'd1, 0, "R7");
      look(20'h00400, 4'd5, 0, "R7");
      idle();
      idle();

      if (!done) begin
         done = 1;
         if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual %0d items left, expected 0", exp_q.size());
         end
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule